// File: doc/BRIEF.md
# Transmitter Laser Enable Controller

This block is the clocked control logic that decides whether a multi-channel laser transmitter may emit light. It watches an active-low laser reset pin, a supply-good indication, a pair of enable pins of opposite polarity, a vector of latching fault flags and a vector of transient duty-cycle alerts from the per-channel safety monitors. It drives a registered global laser-on signal, a per-channel emit signal, a link-ready signal that marks the end of the turn-on delay, and a controller-up status.

Every control pin is asynchronous to the block clock and passes through a two-flop synchronizer whose reset value is the safe state an unconnected pin would settle to: the active-high enable reads high, the active-low enable reads low, and the laser reset and supply-good read low, so the lasers stay dark. A low supply is handled exactly like a held laser reset, which turns the reset pin into a power-on gate. A latched fault is only cleared by a reset that stays low long enough; short glitches on the reset pin leave it in place. No port carries a data stream, so all pins are plain level signals without a handshake.

Top module: `laser_enable_ctrl`

## Requirements
- R1: Each control input passes through a two-flop synchronizer; a change on a pin that is set up before a rising clock edge first shows on the registered outputs after the third rising edge.
- R2: While the laser reset pin is low or supply-good is low, laser_on_o, every bit of chan_on_o and link_ready_o are low, whatever the enable pins are.
- R3: laser_on_o is high only when en_hi_i is 1 and en_lo_n_i is 0 together with reset high, supply good and no latched fault; the other three enable combinations keep it low.
- R4: ctrl_up_o is high exactly when the laser reset pin is high, supply is good and no fault is latched; it does not depend on the enable pins.
- R5: A high level on any bit of fault_i, held for at least one clock cycle, latches a fault that drives laser_on_o and ctrl_up_o low and stays latched after fault_i returns to zero while reset stays high.
- R6: A latched fault is cleared only when the synchronized reset (laser reset low or supply low) is seen on MIN_LOW_CYC or more consecutive cycles; a shorter low pulse leaves the fault latched.
- R7: After the laser reset pin rises (supply good, enables agreeing, no fault), link_ready_o goes high after the (ON_DELAY_CYC+2)-th rising edge, while laser_on_o rises after the third edge.
- R8: alert_i[i] high forces chan_on_o[i] low only, leaves the other channels, laser_on_o and ctrl_up_o unchanged, and does not latch: the channel emits again once the alert drops.
- R9: While the system reset rst_n is low, laser_on_o, chan_on_o, link_ready_o and ctrl_up_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert |
| las_rst_n_i | input | 1 | Laser reset pin, active low, asynchronous |
| supply_ok_i | input | 1 | Supply has reached its minimum level, asynchronous |
| en_hi_i | input | 1 | Laser enable, active high, asynchronous |
| en_lo_n_i | input | 1 | Laser enable, active low, asynchronous |
| fault_i | input | NCH | Per-channel latching laser fault flags, asynchronous |
| alert_i | input | NCH | Per-channel transient duty-cycle alerts, asynchronous |
| laser_on_o | output | 1 | Registered global laser-on to the driver stage |
| chan_on_o | output | NCH | Registered per-channel emit enable |
| link_ready_o | output | 1 | Lasers on and turn-on delay elapsed |
| ctrl_up_o | output | 1 | Controller-up status, high in normal operation |

## Verification
The bench builds the block with NCH=4, MIN_LOW_CYC=4 and ON_DELAY_CYC=6, which shrinks the millisecond-scale windows to a few cycles. That makes it cheap to sweep all sixteen combinations of reset, supply and both enables, every single-channel alert and fault, and every reset pulse width from one cycle up to two beyond the qualifying length. The exact edge at which laser_on_o and link_ready_o rise after reset release is checked cycle by cycle against the synchronizer and delay counts.

// File: rtl/lec_pkg.sv
package lec_pkg;

  // Synchronized control pins, grouped so they share one synchronizer.
  typedef struct packed {
    logic rst_n;
    logic pwr_ok;
    logic en_hi;
    logic en_lo_n;
  } ctl_t;

  // Value an unconnected pin settles to: enables asserted, reset asserted,
  // supply not yet good. Used as the synchronizer reset value.
  localparam ctl_t CTL_OPEN = '{rst_n: 1'b0, pwr_ok: 1'b0, en_hi: 1'b1, en_lo_n: 1'b0};

  function automatic logic enables_agree(input ctl_t c);
    return c.en_hi && !c.en_lo_n;
  endfunction

  function automatic logic hold_active(input ctl_t c);
    return !c.rst_n || !c.pwr_ok;
  endfunction

endpackage

// File: rtl/lec_sync.sv
module lec_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/lec_fault_latch.sv
module lec_fault_latch #(
  parameter int unsigned NCH         = 12,
  parameter int unsigned MIN_LOW_CYC = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold_i,
  input  logic [NCH-1:0] fault_i,
  output logic           latched_o
);

  localparam int unsigned LW = (MIN_LOW_CYC > 1) ? $clog2(MIN_LOW_CYC) : 1;
  localparam logic [LW-1:0] LAST = LW'(MIN_LOW_CYC - 1);

  logic [LW-1:0] low_cnt;
  logic          qualified;
  logic          any_fault;

  assign any_fault = |fault_i;
  assign qualified = hold_i && (low_cnt == LAST);

  // Consecutive cycles of reset, saturating at the qualifying length.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!hold_i) begin
      low_cnt <= '0;
    end else if (low_cnt != LAST) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  // A new fault wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched_o <= 1'b0;
    end else if (qualified) begin
      latched_o <= any_fault;
    end else begin
      latched_o <= latched_o | any_fault;
    end
  end

  // R5: a fault is captured on the next edge
  a_r5_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    any_fault |=> latched_o);

  // R5: without reset the latch holds
  a_r5_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_o && !hold_i) |=> latched_o);

  // R6: a clear needs a full-length reset behind it
  a_r6_long_pulse_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latched_o) |-> ($past(hold_i) && ($past(low_cnt) == LAST)));

endmodule

// File: rtl/lec_turnon_timer.sv
module lec_turnon_timer #(
  parameter int unsigned ON_DELAY_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic ready_o
);

  localparam int unsigned CW = $clog2(ON_DELAY_CYC + 1);
  localparam logic [CW-1:0] DONE = CW'(ON_DELAY_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (hold_i) begin
      cnt <= '0;
    end else if (cnt != DONE) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ready_o = (cnt == DONE);

  // R7: reset restarts the delay
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !ready_o);

  // R7: ready never appears in the cycle right after a reset
  a_r7_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !$past(hold_i));

endmodule

// File: rtl/laser_enable_ctrl.sv
module laser_enable_ctrl
  import lec_pkg::*;
#(
  parameter int unsigned NCH          = 12,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned MIN_LOW_CYC  = 10,
  parameter int unsigned ON_DELAY_CYC = 25_000_000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           las_rst_n_i,
  input  logic           supply_ok_i,
  input  logic           en_hi_i,
  input  logic           en_lo_n_i,
  input  logic [NCH-1:0] fault_i,
  input  logic [NCH-1:0] alert_i,
  output logic           laser_on_o,
  output logic [NCH-1:0] chan_on_o,
  output logic           link_ready_o,
  output logic           ctrl_up_o
);

  localparam int unsigned CTLW = $bits(ctl_t);

  ctl_t           ctl_raw;
  ctl_t           ctl_s;
  logic [NCH-1:0] fault_s;
  logic [NCH-1:0] alert_s;
  logic           hold;
  logic           en_ok;
  logic           fault_lat;
  logic           delay_done;
  logic           laser_d;
  logic           laser_on_q;
  logic [NCH-1:0] chan_on_q;
  logic           ctrl_up_q;

  assign ctl_raw = '{rst_n: las_rst_n_i, pwr_ok: supply_ok_i,
                     en_hi: en_hi_i, en_lo_n: en_lo_n_i};

  lec_sync #(.W(CTLW), .STAGES(SYNC_STAGES), .RST_VAL(CTL_OPEN)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ctl_raw), .q_o(ctl_s)
  );

  lec_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_fault_sync (
    .clk(clk), .rst_n(rst_n), .d_i(fault_i), .q_o(fault_s)
  );

  lec_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_alert_sync (
    .clk(clk), .rst_n(rst_n), .d_i(alert_i), .q_o(alert_s)
  );

  assign hold  = hold_active(ctl_s);
  assign en_ok = enables_agree(ctl_s);

  lec_fault_latch #(.NCH(NCH), .MIN_LOW_CYC(MIN_LOW_CYC)) u_fault_latch (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .fault_i(fault_s), .latched_o(fault_lat)
  );

  lec_turnon_timer #(.ON_DELAY_CYC(ON_DELAY_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .ready_o(delay_done)
  );

  assign laser_d = !hold && en_ok && !fault_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      laser_on_q <= 1'b0;
      ctrl_up_q  <= 1'b0;
    end else begin
      laser_on_q <= laser_d;
      ctrl_up_q  <= !hold && !fault_lat;
    end
  end

  // Per-channel gating by the transient alerts; nothing is remembered.
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chan_on_q[g] <= 1'b0;
      else        chan_on_q[g] <= laser_d && !alert_s[g];
    end
  end

  assign laser_on_o   = laser_on_q;
  assign chan_on_o    = chan_on_q;
  assign ctrl_up_o    = ctrl_up_q;
  assign link_ready_o = laser_on_q && delay_done;

  // R2: reset or low supply darkens every output on the next edge
  a_r2_hold_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!laser_on_q && (chan_on_q == '0) && !link_ready_o));

  // R3: emission only follows agreeing enables
  a_r3_needs_both_enables: assert property (@(posedge clk) disable iff (!rst_n)
    laser_on_q |-> $past(en_ok));

  // R4: status up only when out of reset and fault free
  a_r4_status_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_up_q |-> $past(!hold && !fault_lat));

  // R8: an alerted channel never emits
  a_r8_alert_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on_q & $past(alert_s)) == '0);

  // R8: alerts never touch the status output
  a_r8_alert_no_status: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_up_q) |-> $past(hold || fault_lat));

endmodule

// File: tb/laser_enable_ctrl_bench.sv
module laser_enable_ctrl_bench;

  localparam int NCH   = 4;
  localparam int MINL  = 4;
  localparam int DLY   = 6;
  localparam logic [NCH-1:0] ALL = '1;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           las_rst_n, supply_ok, en_hi, en_lo_n;
  logic [NCH-1:0] fault, alert;
  logic           laser_on, link_ready, ctrl_up;
  logic [NCH-1:0] chan_on;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  laser_enable_ctrl #(
    .NCH(NCH), .SYNC_STAGES(2), .MIN_LOW_CYC(MINL), .ON_DELAY_CYC(DLY)
  ) u_laser_enable_ctrl (
    .clk(clk), .rst_n(rst_n), .las_rst_n_i(las_rst_n), .supply_ok_i(supply_ok),
    .en_hi_i(en_hi), .en_lo_n_i(en_lo_n), .fault_i(fault), .alert_i(alert),
    .laser_on_o(laser_on), .chan_on_o(chan_on), .link_ready_o(link_ready),
    .ctrl_up_o(ctrl_up)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_pulse(input int n);
    las_rst_n = 1'b0;
    wait_n(n);
    las_rst_n = 1'b1;
  endtask

  task automatic fault_pulse(input int ch);
    fault[ch] = 1'b1;
    wait_n(1);
    fault = '0;
  endtask

  initial begin
    rst_n = 1'b0; las_rst_n = 1'b0; supply_ok = 1'b0;
    en_hi = 1'b1; en_lo_n = 1'b0; fault = '0; alert = '0;
    wait_n(3);
    chk("R9 laser_on in reset", laser_on, 0);
    chk("R9 chan_on in reset", chan_on, 0);
    chk("R9 link_ready in reset", link_ready, 0);
    chk("R9 ctrl_up in reset", ctrl_up, 0);
    rst_n = 1'b1;
    wait_n(2);

    // R2 R3 R4: every combination of reset, supply and both enables
    for (int v = 0; v < 16; v++) begin
      logic r, p, h, l, exp_on, exp_up;
      {r, p, h, l} = 4'(v);
      las_rst_n = r; supply_ok = p; en_hi = h; en_lo_n = l;
      wait_n(4);
      exp_on = r && p && h && !l;
      exp_up = r && p;
      chk($sformatf("R3 laser_on combo %0d", v), laser_on, exp_on);
      chk($sformatf("R2 chan_on combo %0d", v), chan_on, exp_on ? ALL : '0);
      chk($sformatf("R4 ctrl_up combo %0d", v), ctrl_up, exp_up);
    end

    // R1 R7: exact edges after reset release
    las_rst_n = 1'b0; supply_ok = 1'b1; en_hi = 1'b1; en_lo_n = 1'b0;
    wait_n(6);
    las_rst_n = 1'b1;
    for (int i = 1; i <= DLY + 3; i++) begin
      wait_n(1);
      chk($sformatf("R1 laser_on edge %0d", i), laser_on, (i >= 3));
      chk($sformatf("R7 link_ready edge %0d", i), link_ready, (i >= DLY + 2));
    end
    las_rst_n = 1'b0;
    for (int i = 1; i <= 3; i++) begin
      wait_n(1);
      chk($sformatf("R2 laser_on off edge %0d", i), laser_on, (i < 3));
      chk($sformatf("R2 link_ready off edge %0d", i), link_ready, (i < 3));
    end
    las_rst_n = 1'b1;
    wait_n(DLY + 5);

    // R8: alerts gate single channels and do not latch
    for (int ch = 0; ch < NCH; ch++) begin
      alert = NCH'(1) << ch;
      wait_n(4);
      chk($sformatf("R8 chan_on alert %0d", ch), chan_on, ALL & ~(NCH'(1) << ch));
      chk($sformatf("R8 laser_on alert %0d", ch), laser_on, 1);
      chk($sformatf("R8 ctrl_up alert %0d", ch), ctrl_up, 1);
      alert = '0;
      wait_n(4);
      chk($sformatf("R8 chan_on recovered %0d", ch), chan_on, ALL);
    end
    alert = ALL;
    wait_n(4);
    chk("R8 all alerted chan_on", chan_on, 0);
    chk("R8 all alerted ctrl_up", ctrl_up, 1);
    alert = '0;
    wait_n(4);

    // R5: each channel's fault latches and persists
    for (int ch = 0; ch < NCH; ch++) begin
      fault_pulse(ch);
      wait_n(4);
      chk($sformatf("R5 ctrl_up fault %0d", ch), ctrl_up, 0);
      chk($sformatf("R5 laser_on fault %0d", ch), laser_on, 0);
      wait_n(10);
      chk($sformatf("R5 fault persists %0d", ch), ctrl_up, 0);
      reset_pulse(MINL + 2);
      wait_n(5);
      chk($sformatf("R6 cleared after fault %0d", ch), ctrl_up, 1);
    end

    // R6: sweep reset pulse widths around the qualifying length
    for (int n = 1; n <= MINL + 2; n++) begin
      fault_pulse(n % NCH);
      wait_n(5);
      reset_pulse(n);
      wait_n(5);
      chk($sformatf("R6 ctrl_up after %0d-cycle pulse", n), ctrl_up, (n >= MINL));
      chk($sformatf("R6 laser_on after %0d-cycle pulse", n), laser_on, (n >= MINL));
      if (n < MINL) begin
        reset_pulse(MINL + 2);
        wait_n(5);
      end
    end

    // R6: a low supply of qualifying length also clears
    fault_pulse(1);
    wait_n(5);
    supply_ok = 1'b0;
    wait_n(MINL);
    supply_ok = 1'b1;
    wait_n(5);
    chk("R6 supply dip clears fault", ctrl_up, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule